// File: doc/BRIEF.md
# Bus Cycle Controller with Fail-Safe Timeout and Priority Hold

This block sits between a local processor and a shared system bus on which several masters may live. The local side posts a one-cycle request naming one of four transfer kinds (memory read, memory write, I/O read, I/O write), a 16-bit address and, for writes, an 8-bit datum. The controller puts the address and write data onto the bus, which carries them inverted, and asserts the single active-low command strobe for the transfer kind. It then waits for the target's transfer acknowledge. An early acknowledge lets the local processor stop waiting before the cycle closes, but the bus cycle itself still runs until the transfer acknowledge.

If the addressed device never answers, a fail-safe counter closes the cycle after a set number of clocks. It returns 0xFF as read data and sets a sticky error flag. When another master asks for the bus through the priority hold input, the controller finishes any cycle in progress, floats its drivers and accepts no new work until the hold input drops.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After a synchronous reset, all four command strobes are high, bus drivers are disabled, `loc_done`, `loc_early`, `err_sticky` and `hold_ack` are low, and `req_rdy` is high.
- R2: A request accepted at a clock edge drives `adr_n` = ~address with `bus_oe` high from that edge. The strobe `cmd_n[kind]` goes low one clock later, and the other strobes stay high. The kind encoding is 0 memory read, 1 memory write, 2 I/O read, 3 I/O write.
- R3: For kinds 1 and 3, `wdat_oe` is high and `wdat_n` = ~data while the cycle runs. For kinds 0 and 2, `wdat_oe` is low.
- R4: At the first edge where `xack_n` is sampled low during a command, the strobe returns high and `loc_done` pulses for exactly one clock. For reads, `loc_rdata` = ~`dat_in_n` as sampled at that edge.
- R5: `aack_n` sampled low during a command raises `loc_early` at that edge, while the strobe stays low until the transfer acknowledge.
- R6: If no transfer acknowledge arrives within TMO_CLKS clocks of command assertion, the strobe is released, `loc_done` pulses, `loc_rdata` becomes 0xFF and `err_sticky` goes high and stays high until reset.
- R7: After a cycle ends, `req_rdy` stays low and the bus stays driven until `xack_n` is sampled high. The controller is idle on the clock after that.
- R8: With `hold_req` high while idle, the controller enters a held state on the next edge. In that state `hold_ack` is high, `bus_oe` is low, all strobes are high and requests are ignored. One clock after `hold_req` falls, it is idle again.
- R9: A `hold_req` that rises during a cycle does not cut it short. The command stays asserted until acknowledged, and the hold is granted only after the cycle has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-clock local request strobe, taken when `req_rdy` is high |
| req_kind | input | 2 | Transfer kind: 0 mem rd, 1 mem wr, 2 I/O rd, 3 I/O wr |
| req_addr | input | 16 | Transfer address, bit 15 most significant |
| req_wdata | input | 8 | Write datum, bit 7 most significant |
| req_rdy | output | 1 | Controller idle and able to take a request |
| loc_done | output | 1 | One-clock pulse when a cycle closes |
| loc_early | output | 1 | Early release for the local processor's wait |
| loc_rdata | output | 8 | Read datum of the last read cycle |
| err_sticky | output | 1 | Set by a timed-out cycle, cleared only by reset |
| hold_req | input | 1 | Higher-priority master wants the bus |
| hold_ack | output | 1 | Bus released to the other master |
| bus_oe | output | 1 | Address and strobe drivers enabled |
| adr_n | output | 16 | Inverted address |
| wdat_oe | output | 1 | Data drivers enabled |
| wdat_n | output | 8 | Inverted write data |
| dat_in_n | input | 8 | Inverted data from the bus |
| cmd_n | output | 4 | Active-low strobes indexed by kind |
| xack_n | input | 1 | Transfer acknowledge, active low |
| aack_n | input | 1 | Advance acknowledge, active low |

## Verification
The bench builds the controller with TMO_CLKS set to 8 instead of 64. This lets a timed-out cycle, and an acknowledge one clock before expiry, run in a few dozen clocks. The vector table covers all four transfer kinds, extreme addresses and data, early acknowledges and acknowledge delays from zero up to TMO_CLKS−1. Directed tests then cover the sticky error after a timeout, a hold taken while idle, and a hold raised during a cycle.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  // Transfer kind doubles as the strobe index on cmd_n.
  typedef enum logic [1:0] {
    K_MRD  = 2'd0,
    K_MWR  = 2'd1,
    K_IORD = 2'd2,
    K_IOWR = 2'd3
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_CMD,
    S_RECOV,
    S_HELD
  } state_t;

  function automatic logic kind_is_write(input logic [1:0] k);
    return k[0];
  endfunction
endpackage

// File: rtl/bcc_fail_timer.sv
module bcc_fail_timer #(
  parameter int TMO_CLKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (TMO_CLKS > 2) ? $clog2(TMO_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CLKS - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_cnt_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode #(
  parameter int NCMD = 4
) (
  input  logic [$clog2(NCMD)-1:0] kind,
  input  logic                    active,
  output logic [NCMD-1:0]         cmd_n
);
  localparam int KW = $clog2(NCMD);

  for (genvar g = 0; g < NCMD; g++) begin : g_strobe
    assign cmd_n[g] = !(active && (kind == KW'(g)));
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int TMO_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_rdy,
  output logic          loc_done,
  output logic          loc_early,
  output logic [DW-1:0] loc_rdata,
  output logic          err_sticky,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic          bus_oe,
  output logic [AW-1:0] adr_n,
  output logic          wdat_oe,
  output logic [DW-1:0] wdat_n,
  input  logic [DW-1:0] dat_in_n,
  output logic [3:0]    cmd_n,
  input  logic          xack_n,
  input  logic          aack_n
);
  localparam int NCMD = 4;

  state_t        state, state_n;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q, early_q, err_q, oe_q, hack_q;
  logic [NCMD-1:0] cmd_q, cmd_dec;
  logic          expire;

  bcc_fail_timer #(.TMO_CLKS(TMO_CLKS)) u_timer (
    .clk(clk), .rst(rst), .run(state == S_CMD), .expire(expire)
  );

  bcc_cmd_decode #(.NCMD(NCMD)) u_dec (
    .kind(kind_q), .active(state_n == S_CMD), .cmd_n(cmd_dec)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:  if (hold_req) state_n = S_HELD;
               else if (req_valid) state_n = S_SETUP;
      S_SETUP: state_n = S_CMD;
      S_CMD:   if (!xack_n || expire) state_n = S_RECOV;
      S_RECOV: if (xack_n) state_n = S_IDLE;
      S_HELD:  if (!hold_req) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      early_q <= 1'b0;
      err_q   <= 1'b0;
      oe_q    <= 1'b0;
      hack_q  <= 1'b0;
      cmd_q   <= '1;
    end else begin
      state   <= state_n;
      cmd_q   <= cmd_dec;
      oe_q    <= (state_n == S_SETUP) || (state_n == S_CMD) || (state_n == S_RECOV);
      hack_q  <= (state_n == S_HELD);
      early_q <= (state_n == S_CMD) && (early_q || !aack_n);
      done_q  <= 1'b0;
      if (state == S_IDLE && state_n == S_SETUP) begin
        kind_q  <= req_kind;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (state == S_CMD) begin
        if (!xack_n) begin
          done_q <= 1'b1;
          if (!kind_is_write(kind_q)) rdata_q <= ~dat_in_n;
        end else if (expire) begin
          done_q  <= 1'b1;
          rdata_q <= '1;
          err_q   <= 1'b1;
        end
      end
    end
  end

  assign req_rdy    = (state == S_IDLE) && !hold_req;
  assign loc_done   = done_q;
  assign loc_early  = early_q;
  assign loc_rdata  = rdata_q;
  assign err_sticky = err_q;
  assign hold_ack   = hack_q;
  assign bus_oe     = oe_q;
  assign cmd_n      = cmd_q;
  assign wdat_oe    = oe_q && kind_is_write(kind_q);
  assign adr_n      = oe_q ? ~addr_q : '1;
  assign wdat_n     = wdat_oe ? ~wdata_q : '1;

  p_cmd_needs_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_n != '1) |-> bus_oe);
  p_cmd_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && !xack_n) |=> (cmd_n == '1 && loc_done));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    loc_done |=> !loc_done);
  p_early_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    loc_early |-> (cmd_n != '1));
  p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && xack_n && expire) |=> (err_sticky && loc_rdata == '1));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
  p_recov_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_RECOV && !xack_n) |=> (bus_oe && state == S_RECOV));
  p_held_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (cmd_n == '1 && !bus_oe));
  p_hold_defer_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_CMD && hold_req && xack_n && !expire) |=> (state == S_CMD && !hold_ack));
endmodule

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_rdy, loc_done, loc_early, err_sticky, hold_req, hold_ack;
  logic [7:0]  loc_rdata, wdat_n, dat_in_n;
  logic        bus_oe, wdat_oe, xack_n, aack_n;
  logic [15:0] adr_n;
  logic [3:0]  cmd_n;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bus_cycle_ctrl #(.AW(16), .DW(8), .TMO_CLKS(TMO)) i_bus_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdy(req_rdy),
    .loc_done(loc_done), .loc_early(loc_early), .loc_rdata(loc_rdata),
    .err_sticky(err_sticky), .hold_req(hold_req), .hold_ack(hold_ack),
    .bus_oe(bus_oe), .adr_n(adr_n), .wdat_oe(wdat_oe), .wdat_n(wdat_n),
    .dat_in_n(dat_in_n), .cmd_n(cmd_n), .xack_n(xack_n), .aack_n(aack_n)
  );

  // kind(2) addr(16) wdata(8) rdin(8) dly(4) aack(1) tmo(1)
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 16'h1234, 8'h00, 8'hA5, 4'd0, 1'b0, 1'b0},
    {2'd1, 16'hFFFF, 8'h3C, 8'h00, 4'd2, 1'b0, 1'b0},
    {2'd2, 16'h0080, 8'h00, 8'h00, 4'd3, 1'b1, 1'b0},
    {2'd3, 16'h8001, 8'hFF, 8'h00, 4'd7, 1'b1, 1'b0},
    {2'd0, 16'h0000, 8'h00, 8'h5A, 4'd1, 1'b1, 1'b0},
    {2'd2, 16'h00FE, 8'h00, 8'h77, 4'd0, 1'b0, 1'b1},
    {2'd1, 16'h4321, 8'h81, 8'h00, 4'd0, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_req(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_wdata = '0;
    hold_req = 1'b0; xack_n = 1'b1; aack_n = 1'b1; dat_in_n = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_n == 4'hF, "R1 cmd_n", 32'(cmd_n), 32'hF);
    chk(!bus_oe && !wdat_oe, "R1 drivers", 32'(bus_oe), 0);
    chk(!loc_done && !loc_early && !err_sticky && !hold_ack, "R1 flags", 32'(err_sticky), 0);
    chk(req_rdy, "R1 req_rdy", 32'(req_rdy), 1);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] k; logic [15:0] a; logic [7:0] wd, rd; logic [3:0] dly; logic aa, to;
      {k, a, wd, rd, dly, aa, to} = VEC[v];
      start_req(k, a, wd);
      // R2 address phase, strobe not yet asserted
      chk(bus_oe && adr_n == ~a, "R2 address", 32'(adr_n), 32'(~a));
      chk(cmd_n == 4'hF, "R2 setup strobe", 32'(cmd_n), 32'hF);
      @(negedge clk);
      chk(cmd_n == ~(4'b1 << k), "R2 strobe", 32'(cmd_n), 32'(~(4'b1 << k)));
      // R3 write data drive
      if (k[0]) chk(wdat_oe && wdat_n == ~wd, "R3 wdata", 32'(wdat_n), 32'(~wd));
      else      chk(!wdat_oe, "R3 no wdata on read", 32'(wdat_oe), 0);
      if (to) begin
        for (int i = 0; i < TMO - 1; i++) @(negedge clk);
        chk(cmd_n == ~(4'b1 << k) && !err_sticky, "R6 before expiry", 32'(cmd_n), 32'(~(4'b1 << k)));
        @(negedge clk);
        chk(cmd_n == 4'hF && loc_done, "R6 timeout close", 32'(cmd_n), 32'hF);
        chk(loc_rdata == 8'hFF && err_sticky, "R6 rdata FF", 32'(loc_rdata), 32'hFF);
        @(negedge clk);
        chk(req_rdy && !bus_oe, "R7 idle after timeout", 32'(req_rdy), 1);
      end else begin
        if (aa) aack_n = 1'b0;
        for (int i = 0; i < int'(dly); i++) begin
          @(negedge clk);
          if (aa) chk(loc_early && cmd_n != 4'hF, "R5 early keeps strobe", 32'(cmd_n), 32'(~(4'b1 << k)));
        end
        chk(cmd_n == ~(4'b1 << k) && !loc_done, "R4 waiting", 32'(cmd_n), 32'(~(4'b1 << k)));
        xack_n = 1'b0; dat_in_n = ~rd;
        @(negedge clk);
        aack_n = 1'b1;
        chk(cmd_n == 4'hF && loc_done, "R4 close on xack", 32'(cmd_n), 32'hF);
        if (!k[0]) chk(loc_rdata == rd, "R4 read data", 32'(loc_rdata), 32'(rd));
        @(negedge clk);
        chk(!loc_done, "R4 done pulse", 32'(loc_done), 0);
        chk(!req_rdy && bus_oe, "R7 held while xack low", 32'(req_rdy), 0);
        xack_n = 1'b1; dat_in_n = '1;
        @(negedge clk);
        chk(req_rdy && !bus_oe, "R7 idle after release", 32'(req_rdy), 1);
      end
      chk(err_sticky == (v >= 5), "R6 sticky", 32'(err_sticky), 32'(v >= 5));
    end

    // R8 hold while idle, with a request that must be ignored
    hold_req = 1'b1; req_valid = 1'b1; req_kind = 2'd0; req_addr = 16'h5555;
    @(negedge clk);
    chk(hold_ack && !bus_oe && cmd_n == 4'hF, "R8 held", 32'(hold_ack), 1);
    repeat (3) @(negedge clk);
    chk(hold_ack && !bus_oe && cmd_n == 4'hF, "R8 request ignored", 32'(cmd_n), 32'hF);
    req_valid = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk(!hold_ack && req_rdy && !bus_oe, "R8 resume", 32'(hold_ack), 0);

    // R9 hold raised during a cycle
    start_req(2'd2, 16'h0F0F, 8'h00);
    @(negedge clk);
    hold_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_n == 4'b1011 && !hold_ack, "R9 cycle continues", 32'(cmd_n), 32'hB);
    xack_n = 1'b0; dat_in_n = ~8'hC3;
    @(negedge clk);
    chk(loc_done && loc_rdata == 8'hC3 && !hold_ack, "R9 cycle completes", 32'(loc_rdata), 32'hC3);
    xack_n = 1'b1; dat_in_n = '1;
    @(negedge clk);
    chk(!hold_ack && !bus_oe, "R9 idle before grant", 32'(hold_ack), 0);
    @(negedge clk);
    chk(hold_ack, "R9 grant after cycle", 32'(hold_ack), 1);
    hold_req = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule